// File: doc/BRIEF.md
# Page access permission checker

This block sits between a translation lookaside buffer lookup and a data cache pipeline. For each load or store it takes the attribute bits of the matching page table entry, whether translation is on, whether the requester runs in user (problem) state, whether the request is already marked non-cacheable, and whether the lookup found a translation. From these it decides whether the access may go ahead.

One clock after a valid request it gives one of two results. The first is a proceed pulse, which comes with an effective cache-inhibit flag. The second is a fault pulse, which comes with a 64-bit syndrome word. The syndrome records exactly one cause, plus a flag that marks the faulting access as a store. The syndrome keeps its value until the next fault, so the exception logic downstream can read it at any later time.

When translation is off, the entry and the lookup result have no effect. A fixed attribute set grants every right and leaves caching on, so every access proceeds.

Top module: `pgperm_check`

## Requirements
- R1: One cycle after a cycle with req_valid=1, exactly one of go and fault_valid is 1, and each is a single-cycle pulse. One cycle after a cycle with req_valid=0, go, go_nocache and fault_valid are all 0.
- R2: With req_translate=0 every valid request gives go=1, whatever the values of tlb_hit and pte, and go_nocache then equals req_nocache.
- R3: With req_translate=1 and tlb_hit=0 the request faults. The syndrome has bit 30 set (little-endian index) and bits 27 and 18 clear, whatever the entry holds.
- R4: When the translation is valid, pte[3] (privileged-only) is 1 and req_user=1, the request faults with syndrome bit 27 set and bits 30 and 18 clear.
- R5: When the translation is valid, a store needs pte[1] (write) = 1, and a load needs pte[2] (read) = 1 or pte[1] = 1. If this rule fails, the request faults with only bit 27 of the three cause bits set.
- R6: When the translation is valid and the permission checks of R4 and R5 pass, pte[8] (reference) must be 1, and for a store pte[7] (change) must also be 1. If this fails, the request faults with only bit 18 of the cause bits set.
- R7: Syndrome bit 25 is 1 when the faulting access is a store and 0 when it is a load. No other syndrome bit apart from 30, 27, 25 and 18 is ever set.
- R8: On go, go_nocache is 1 if req_nocache is 1, or if translation is on and pte[5] (cache-inhibit) is 1. Otherwise it is 0.
- R9: A synchronous reset clears the syndrome and all pulses. The syndrome keeps its value through cycles with no fault and is replaced as a whole on each new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_user | input | 1 | Requester is in user (problem) state |
| req_translate | input | 1 | Translation on; 0 selects real mode |
| req_nocache | input | 1 | Request already marked non-cacheable |
| tlb_hit | input | 1 | Lookup found a translation |
| pte | input | PTE_W | Page table entry attribute bits |
| go | output | 1 | Access may proceed (registered pulse) |
| go_nocache | output | 1 | Effective cache-inhibit, qualified by go |
| fault_valid | output | 1 | Access refused (registered pulse) |
| syndrome | output | 64 | Cause word of the last fault |

## Verification
The assertions check the following on every cycle: go and fault are never both high, an idle cycle is always followed by quiet outputs, a fault carries exactly one cause bit, go_nocache never appears without go, the syndrome does not move between faults, and real-mode requests always proceed. What the assertions cannot show is whether the chosen cause is the right one. The priority of a miss over a permission failure, and of a permission failure over a reference/change failure, the load/store asymmetry of the rights and of the change bit, and the cache-inhibit merge can only be shown by comparing against the bench's own model. That model runs on directed corner cases and on random entries.

// File: rtl/pgperm_check.sv
module pgperm_check #(
  parameter int PTE_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             req_user,
  input  logic             req_translate,
  input  logic             req_nocache,
  input  logic             tlb_hit,
  input  logic [PTE_W-1:0] pte,
  output logic             go,
  output logic             go_nocache,
  output logic             fault_valid,
  output logic [63:0]      syndrome
);
  localparam int PB_REF  = 8;
  localparam int PB_CHG  = 7;
  localparam int PB_CI   = 5;
  localparam int PB_PRIV = 3;
  localparam int PB_RD   = 2;
  localparam int PB_WR   = 1;
  localparam int SB_MISS  = 30;
  localparam int SB_PERM  = 27;
  localparam int SB_STORE = 25;
  localparam int SB_RC    = 18;

  logic a_ref, a_chg, a_ci, a_priv, a_rd, a_wr;
  logic miss, perm_ok, rc_ok, ok, eff_nc;
  logic [63:0] syn_next;

  assign a_ref  = ~req_translate | pte[PB_REF];
  assign a_chg  = ~req_translate | pte[PB_CHG];
  assign a_ci   =  req_translate & pte[PB_CI];
  assign a_priv =  req_translate & pte[PB_PRIV];
  assign a_rd   = ~req_translate | pte[PB_RD];
  assign a_wr   = ~req_translate | pte[PB_WR];

  assign miss    = req_translate & ~tlb_hit;
  assign perm_ok = ~(a_priv & req_user) & (a_wr | (~req_store & a_rd));
  assign rc_ok   = a_ref & (~req_store | a_chg);
  assign ok      = ~miss & perm_ok & rc_ok;
  assign eff_nc  = req_nocache | a_ci;

  always_comb begin
    syn_next = '0;
    syn_next[SB_MISS]  = miss;
    syn_next[SB_PERM]  = ~miss & ~perm_ok;
    syn_next[SB_RC]    = ~miss & perm_ok & ~rc_ok;
    syn_next[SB_STORE] = req_store;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go          <= 1'b0;
      go_nocache  <= 1'b0;
      fault_valid <= 1'b0;
      syndrome    <= '0;
    end else begin
      go          <= req_valid & ok;
      go_nocache  <= req_valid & ok & eff_nc;
      fault_valid <= req_valid & ~ok;
      if (req_valid & ~ok)
        syndrome <= syn_next;
    end
  end
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_translate,
  input logic        go,
  input logic        go_nocache,
  input logic        fault_valid,
  input logic [63:0] syndrome
);
  AST_GO_XOR_FAULT: assert property (@(posedge clk) disable iff (rst)
    !(go && fault_valid)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!go && !fault_valid && !go_nocache)); // R1
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (go || fault_valid)); // R1
  AST_REAL_MODE_GO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_translate) |=> go); // R2
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> ($countones({syndrome[30], syndrome[27], syndrome[18]}) == 1)); // R3
  AST_NC_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
    go_nocache |-> go); // R8
  AST_SYN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |-> $stable(syndrome)); // R9
endmodule

bind pgperm_check pgperm_check_sva u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_translate(req_translate),
  .go(go), .go_nocache(go_nocache), .fault_valid(fault_valid), .syndrome(syndrome)
);

// File: tb/test_pgperm_check.sv
module test_pgperm_check;
  localparam int PTE_W = 64;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_store, req_user, req_translate, req_nocache, tlb_hit;
  logic [PTE_W-1:0] pte;
  logic go, go_nocache, fault_valid;
  logic [63:0] syndrome;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_syn = '0;

  always #10ns clk = ~clk;

  pgperm_check #(.PTE_W(PTE_W)) i_pgperm_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_user(req_user), .req_translate(req_translate), .req_nocache(req_nocache),
    .tlb_hit(tlb_hit), .pte(pte), .go(go), .go_nocache(go_nocache),
    .fault_valid(fault_valid), .syndrome(syndrome)
  );

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got go/nc/fault/syn=%b/%b/%b/%h expected %b/%b/%b/%h", tag,
               act[66], act[65], act[64], act[63:0], exp[66], exp[65], exp[64], exp[63:0]);
    end
  endtask

  task automatic req(input string tag, input logic st, input logic usr, input logic xl,
                     input logic nc, input logic hit, input logic [PTE_W-1:0] p);
    logic miss, pok, rok, ok;
    logic [63:0] s;
    logic [66:0] e;
    req_valid = 1'b1; req_store = st; req_user = usr; req_translate = xl;
    req_nocache = nc; tlb_hit = hit; pte = p;
    miss = xl && !hit;
    pok  = !xl || (!(p[3] && usr) && (p[1] || (!st && p[2])));
    rok  = !xl || (p[8] && (!st || p[7]));
    ok   = !miss && pok && rok;
    if (!ok) begin
      s = '0;
      if (miss) s[30] = 1'b1;
      else if (!pok) s[27] = 1'b1;
      else s[18] = 1'b1;
      s[25] = st;
      exp_syn = s;
    end
    e = {ok, ok && (nc || (xl && p[5])), !ok, exp_syn};
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {go, go_nocache, fault_valid, syndrome}, e);
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    check(tag, {go, go_nocache, fault_valid, syndrome}, {3'b000, exp_syn});
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    string tag;
    logic [PTE_W-1:0] rp;
    logic rst_, rs, ru, rx, rn, rh;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_user = 1'b0;
    req_translate = 1'b0; req_nocache = 1'b0; tlb_hit = 1'b0; pte = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", {go, go_nocache, fault_valid, syndrome}, 67'd0);
    rst = 1'b0;
    idle("R1 idle");
    req("R2 real mode store, empty entry, miss", 1, 1, 0, 0, 0, '0);
    req("R2 real mode load nocache", 0, 1, 0, 1, 0, 64'h20);
    req("R3 miss store", 1, 0, 1, 0, 0, 64'h1FF);
    req("R9 hold after go", 0, 0, 1, 0, 1, 64'h106);
    idle("R9 hold idle");
    req("R3 miss beats bad perm", 0, 1, 1, 0, 0, 64'h008);
    req("R4 priv page user", 0, 1, 1, 0, 1, 64'h18E);
    req("R4 priv page supervisor ok", 0, 0, 1, 0, 1, 64'h18E);
    req("R5 store no write", 1, 0, 1, 0, 1, 64'h184);
    req("R5 load write only ok", 0, 0, 1, 0, 1, 64'h102);
    req("R5 load no rights", 0, 0, 1, 0, 1, 64'h180);
    req("R4 perm beats rc", 1, 1, 1, 0, 1, 64'h00A);
    req("R6 store change clear", 1, 0, 1, 0, 1, 64'h106);
    req("R6 load ref clear", 0, 0, 1, 0, 1, 64'h086);
    req("R6 load change clear ok", 0, 0, 1, 0, 1, 64'h104);
    req("R7 load fault store flag clear", 0, 0, 1, 0, 1, 64'h000);
    req("R8 pte cache inhibit", 1, 0, 1, 0, 1, 64'h1A2);
    req("R8 real mode ignores pte inhibit", 0, 0, 0, 0, 1, 64'h020);
    for (int i = 0; i < 400; i++) begin
      rs = 1'($urandom); ru = 1'($urandom); rx = ($urandom % 4) != 0;
      rn = ($urandom % 4) == 0; rh = ($urandom % 8) != 0;
      rp = {$urandom, $urandom};
      rst_ = ($urandom % 5) == 0;
      tag = !rx ? "R2 random" : !rh ? "R3 random" : "R5 R6 R7 R8 random";
      if (rst_) idle("R1 random idle");
      else req(tag, rs, ru, rx, rn, rh, rp);
    end
    idle("R1 final idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule